// File: doc/BRIEF.md
# Fixed-I/O DMA Channel

A single DMA channel that moves one byte or one 16-bit word for every transfer request it accepts. One side of each move is a 24-bit memory pointer that steps up or down after every transfer. The other side is a fixed I/O location. It is set by an 8-bit register, and the 16 bits above that register always read as ones. A 16-bit count register is reduced by one per transfer. When it reaches zero the channel switches itself off and raises a sticky completion flag.

The request source sets the direction of each move. A request flagged as coming from the serial receiver's data-full event copies from the I/O location into memory. Any other request copies from memory to the I/O location. Each move is a read bus cycle from the source, then a write bus cycle to the destination, over a valid/ready single-transaction master port. Software programs the channel through a small indexed register write port. A request that arrives while a move is in flight is kept, but only one.

Top module: `dma_fixio_chan`

## Requirements
- R1: After reset every register is zero, the channel is disabled, the done flag is low and no bus cycle is requested. Register writes use `cfg_addr`: index 0 loads the 24-bit memory pointer, index 1 loads the 8-bit I/O low byte, index 2 loads the 16-bit count and index 3 is control. In the control value, bit 0 enables the channel, bit 1 selects word size and bit 2 selects the downward pointer step. A control write with bit 0 set clears the done flag.
- R2: Each accepted request produces exactly one read cycle (`bus_write`=0) followed by exactly one write cycle (`bus_write`=1). `busy` is high from the cycle after acceptance until the write is acknowledged. `bus_size` is 1 for word and 0 for byte.
- R3: A request with `req_rx`=1 reads from the I/O address and writes to the memory pointer. A request with `req_rx`=0 reads from the memory pointer and writes to the I/O address.
- R4: The I/O address is the 8-bit I/O register with its upper 16 bits all ones, and no transfer ever changes it.
- R5: The memory pointer changes only when a write cycle is acknowledged (or by a register write). It then moves by 1 in byte mode or by 2 in word mode, upward or downward as selected.
- R6: The count drops by one on each acknowledged write cycle. When it becomes zero, the enable bit clears and the done flag sets in the same clock.
- R7: The done flag stays set until a control write with bit 0 set. While the channel is disabled, including after completion, requests start no bus cycle and change no register.
- R8: A request that arrives while a move is in flight is held, with its direction, and is serviced once the current move ends. Further requests during that time are dropped.
- R9: While `bus_valid` is high and `bus_ready` is low, the address, write flag, write data and size stay unchanged.
- R10: In word mode the write data equals the full 16-bit read data. In byte mode it is the low read byte with the upper 8 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 24 | Register write value |
| req_valid | input | 1 | Transfer request pulse |
| req_rx | input | 1 | Request comes from the serial receiver data-full event |
| bus_ready | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 16 | Read data |
| bus_valid | output | 1 | Bus cycle request |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size | output | 1 | 1 = word, 0 = byte |
| bus_addr | output | 24 | Bus cycle address |
| bus_wdata | output | 16 | Write data |
| busy | output | 1 | A move is in flight |
| ch_enable | output | 1 | Channel enable state |
| ch_done | output | 1 | Sticky completion flag |
| ch_mem_addr | output | 24 | Current memory pointer |
| ch_count | output | 16 | Remaining transfer count |

## Verification
The assertions check on every cycle the properties that hold from one cycle to the next. These are: a waiting bus cycle stays stable, a read is always followed by a write, the pointer and the count change only at the write acknowledge and by the right amount, the I/O side carries the all-ones upper address, and a disabled idle channel stays off the bus. The bench scenarios are needed for the behaviour that depends on a sequence of events. That covers the direction chosen per request source, the single held request and the dropping of extra requests, the byte-lane data of byte mode, and the channel stopping at zero and then ignoring requests until software enables it again.

// File: rtl/dma_fixio_pkg.sv
package dma_fixio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  localparam logic [1:0] RIX_MEM  = 2'd0;
  localparam logic [1:0] RIX_IO   = 2'd1;
  localparam logic [1:0] RIX_CNT  = 2'd2;
  localparam logic [1:0] RIX_CTRL = 2'd3;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WORD_BIT = 1;
  localparam int CTRL_DOWN_BIT = 2;
  localparam int CTRL_W        = 3;

endpackage

// File: rtl/dma_fixio_stepreg.sv
module dma_fixio_stepreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         down,
  input  logic [W-1:0] delta,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         q_ce;

  always_comb begin
    q_nxt = q;
    if (load) begin
      q_nxt = load_val;
    end else if (step_en) begin
      q_nxt = down ? (q - delta) : (q + delta);
    end
  end

  assign q_ce = load | step_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_ce) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/dma_fixio_cfg.sv
module dma_fixio_cfg
  import dma_fixio_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [IO_W-1:0]   io_wdata,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              finish,
  output logic [IO_W-1:0]   io_lo,
  output logic              en,
  output logic              word,
  output logic              down,
  output logic              done
);

  logic io_wr;
  logic ctrl_wr;
  logic en_nxt;
  logic done_nxt;
  logic flag_ce;

  assign io_wr   = cfg_we && (cfg_addr == RIX_IO);
  assign ctrl_wr = cfg_we && (cfg_addr == RIX_CTRL);

  always_comb begin
    en_nxt   = en;
    done_nxt = done;
    if (finish) begin
      en_nxt   = 1'b0;
      done_nxt = 1'b1;
    end
    if (ctrl_wr) begin
      en_nxt = ctrl_wdata[CTRL_EN_BIT];
      if (ctrl_wdata[CTRL_EN_BIT] && !finish) begin
        done_nxt = 1'b0;
      end
    end
  end

  assign flag_ce = finish | ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_lo <= '0;
    end else if (io_wr) begin
      io_lo <= io_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= 1'b0;
      down <= 1'b0;
    end else if (ctrl_wr) begin
      word <= ctrl_wdata[CTRL_WORD_BIT];
      down <= ctrl_wdata[CTRL_DOWN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      done <= 1'b0;
    end else if (flag_ce) begin
      en   <= en_nxt;
      done <= done_nxt;
    end
  end

endmodule

// File: rtl/dma_fixio_seq.sv
module dma_fixio_seq
  import dma_fixio_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              word,
  input  logic              req_valid,
  input  logic              req_rx,
  input  logic              cnt_last,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic              xfer_done,
  output logic              finish
);

  localparam int BYTE_W = 8;
  localparam int HI_W   = DATA_W - BYTE_W;

  phase_e            ph, ph_nxt;
  logic              dir_rx, dir_nxt;
  logic              pend_v, pv_nxt;
  logic              pend_rx, prx_nxt;
  logic [DATA_W-1:0] data_q, data_nxt;
  logic              start;
  logic              ctl_ce;
  logic              data_ce;
  logic [ADDR_W-1:0] src_addr;
  logic [ADDR_W-1:0] dst_addr;

  assign start     = (ph == PH_IDLE) && en && (pend_v || req_valid);
  assign xfer_done = (ph == PH_WRITE) && bus_ready;
  assign finish    = xfer_done && cnt_last;

  always_comb begin
    ph_nxt   = ph;
    dir_nxt  = dir_rx;
    pv_nxt   = pend_v;
    prx_nxt  = pend_rx;
    data_nxt = data_q;
    case (ph)
      PH_IDLE: begin
        if (start) begin
          ph_nxt  = PH_READ;
          dir_nxt = pend_v ? pend_rx : req_rx;
          pv_nxt  = pend_v && req_valid;
          prx_nxt = req_rx;
        end
      end
      PH_READ: begin
        if (bus_ready) begin
          ph_nxt   = PH_WRITE;
          data_nxt = word ? bus_rdata : {{HI_W{1'b0}}, bus_rdata[BYTE_W-1:0]};
        end
      end
      PH_WRITE: begin
        if (bus_ready) begin
          ph_nxt = PH_IDLE;
        end
      end
      default: ph_nxt = PH_IDLE;
    endcase
    if ((ph != PH_IDLE) && en && req_valid && !pend_v) begin
      pv_nxt  = 1'b1;
      prx_nxt = req_rx;
    end
    if (finish) begin
      pv_nxt = 1'b0;
    end
  end

  assign ctl_ce  = start || bus_ready || req_valid || finish;
  assign data_ce = (ph == PH_READ) && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      dir_rx  <= 1'b0;
      pend_v  <= 1'b0;
      pend_rx <= 1'b0;
    end else if (ctl_ce) begin
      ph      <= ph_nxt;
      dir_rx  <= dir_nxt;
      pend_v  <= pv_nxt;
      pend_rx <= prx_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_ce) begin
      data_q <= data_nxt;
    end
  end

  assign src_addr  = dir_rx ? io_addr : mem_addr;
  assign dst_addr  = dir_rx ? mem_addr : io_addr;
  assign bus_valid = (ph != PH_IDLE);
  assign bus_write = (ph == PH_WRITE);
  assign bus_size  = word;
  assign bus_addr  = (ph == PH_WRITE) ? dst_addr : src_addr;
  assign bus_wdata = data_q;
  assign busy      = (ph != PH_IDLE);

endmodule

// File: rtl/dma_fixio_chan.sv
module dma_fixio_chan
  import dma_fixio_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_rx,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic              bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              busy,
  output logic              ch_enable,
  output logic              ch_done,
  output logic [ADDR_W-1:0] ch_mem_addr,
  output logic [CNT_W-1:0]  ch_count
);

  localparam int                PAD_W   = ADDR_W - IO_W;
  localparam logic [ADDR_W-1:0] STEP_B  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_WD = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [IO_W-1:0]   io_lo;
  logic              cfg_word;
  logic              cfg_down;
  logic              xfer_done;
  logic              finish;
  logic              cnt_last;
  logic              mem_load;
  logic              cnt_load;
  logic [ADDR_W-1:0] io_addr;
  logic [ADDR_W-1:0] mem_delta;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign io_addr   = {{PAD_W{1'b1}}, io_lo};
  assign mem_delta = cfg_word ? STEP_WD : STEP_B;
  assign mem_load  = cfg_we && (cfg_addr == RIX_MEM);
  assign cnt_load  = cfg_we && (cfg_addr == RIX_CNT);
  assign cnt_last  = (ch_count == CNT_ONE);

  dma_fixio_cfg #(
    .IO_W (IO_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .io_wdata   (cfg_wdata[IO_W-1:0]),
    .ctrl_wdata (cfg_wdata[CTRL_W-1:0]),
    .finish     (finish),
    .io_lo      (io_lo),
    .en         (ch_enable),
    .word       (cfg_word),
    .down       (cfg_down),
    .done       (ch_done)
  );

  dma_fixio_stepreg #(
    .W (ADDR_W)
  ) u_mem_ptr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (mem_load),
    .load_val (cfg_wdata),
    .step_en  (xfer_done),
    .down     (cfg_down),
    .delta    (mem_delta),
    .q        (ch_mem_addr)
  );

  dma_fixio_stepreg #(
    .W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cfg_wdata[CNT_W-1:0]),
    .step_en  (xfer_done),
    .down     (1'b1),
    .delta    (CNT_ONE),
    .q        (ch_count)
  );

  dma_fixio_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (ch_enable),
    .word      (cfg_word),
    .req_valid (req_valid),
    .req_rx    (req_rx),
    .cnt_last  (cnt_last),
    .mem_addr  (ch_mem_addr),
    .io_addr   (io_addr),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .xfer_done (xfer_done),
    .finish    (finish)
  );

endmodule

// File: rtl/dma_fixio_chan_chk.sv
module dma_fixio_chan_chk #(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic              bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              ch_enable,
  input logic              ch_done,
  input logic [ADDR_W-1:0] ch_mem_addr,
  input logic [CNT_W-1:0]  ch_count,
  input logic              cfg_down
);

  logic wr_ack;
  assign wr_ack = bus_valid && bus_ready && bus_write;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write)
                                && $stable(bus_wdata) && $stable(bus_size));

  // R2
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_write |=> bus_valid && bus_write);

  // R4
  io_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && (bus_addr != ch_mem_addr) |-> (&bus_addr[ADDR_W-1:IO_W]));

  // R6
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && !cfg_we |=> ch_count == ($past(ch_count) - {{(CNT_W-1){1'b0}}, 1'b1}));

  // R5
  mem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack && !cfg_we |=> ch_mem_addr == ($past(cfg_down)
      ? ($past(ch_mem_addr) - ($past(bus_size) ? ADDR_W'(2) : ADDR_W'(1)))
      : ($past(ch_mem_addr) + ($past(bus_size) ? ADDR_W'(2) : ADDR_W'(1)))));

  // R5
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack && !cfg_we |=> $stable(ch_mem_addr) && $stable(ch_count));

  // R6
  done_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch_done) |-> !ch_enable);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_done && !cfg_we |=> ch_done);

  // R7
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enable && !busy |=> !bus_valid);

endmodule

bind dma_fixio_chan dma_fixio_chan_chk #(
  .ADDR_W (ADDR_W),
  .IO_W   (IO_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cfg_we      (cfg_we),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_write   (bus_write),
  .bus_size    (bus_size),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .busy        (busy),
  .ch_enable   (ch_enable),
  .ch_done     (ch_done),
  .ch_mem_addr (ch_mem_addr),
  .ch_count    (ch_count),
  .cfg_down    (cfg_down)
);

// File: tb/dma_fixio_chan_bench.sv
`timescale 1ns/1ps
module dma_fixio_chan_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [23:0] cfg_wdata;
  logic        req_valid;
  logic        req_rx;
  logic        bus_ready;
  logic [15:0] bus_rdata;
  logic        bus_valid;
  logic        bus_write;
  logic        bus_size;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        busy;
  logic        ch_enable;
  logic        ch_done;
  logic [23:0] ch_mem_addr;
  logic [15:0] ch_count;

  dma_fixio_chan u_dma_fixio_chan (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .req_valid (req_valid), .req_rx (req_rx),
    .bus_ready (bus_ready), .bus_rdata (bus_rdata), .bus_valid (bus_valid),
    .bus_write (bus_write), .bus_size (bus_size), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .busy (busy), .ch_enable (ch_enable),
    .ch_done (ch_done), .ch_mem_addr (ch_mem_addr), .ch_count (ch_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit fin   = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int          m_ph = 0;
  bit          m_en = 0, m_word = 0, m_down = 0, m_done = 0;
  bit          m_rx = 0, m_pv = 0, m_prx = 0;
  logic [23:0] m_mem = '0;
  logic [7:0]  m_io = '0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_buf = '0;
  int          lat = 0, wcnt = 0;
  bit          hold_pend = 0;
  logic [23:0] hold_addr = '0;

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ 16'hC35A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (cmp_on) begin
      chk("R2 busy", {31'd0, busy}, {31'd0, m_ph != 0});
      chk("R2 bus_valid", {31'd0, bus_valid}, {31'd0, m_ph != 0});
      if (m_ph != 0) chk("R2 bus_write", {31'd0, bus_write}, {31'd0, m_ph == 2});
      chk("R6 count", {16'd0, ch_count}, {16'd0, m_cnt});
      chk("R5 mem pointer", {8'd0, ch_mem_addr}, {8'd0, m_mem});
      chk("R6 enable", {31'd0, ch_enable}, {31'd0, m_en});
      chk("R7 done", {31'd0, ch_done}, {31'd0, m_done});
      if (hold_pend && bus_valid) chk("R9 held address", {8'd0, bus_addr}, {8'd0, hold_addr});
    end
  endtask

  task automatic advance(input bit rq, input bit rx, input bit we,
                         input logic [1:0] wa, input logic [23:0] wd);
    bit hs;
    logic [23:0] ioa, srca, dsta;
    hs   = bus_valid && bus_ready;
    ioa  = {16'hFFFF, m_io};
    srca = m_rx ? ioa : m_mem;
    dsta = m_rx ? m_mem : ioa;
    if (m_ph == 0) begin
      if (m_en && (m_pv || rq)) begin
        m_rx  = m_pv ? m_prx : rx;
        m_pv  = m_pv && rq;
        m_prx = rx;
        m_ph  = 1;
      end
    end else begin
      if (m_en && rq && !m_pv) begin
        m_pv  = 1;
        m_prx = rx;
      end
      if (hs && m_ph == 1) begin
        chk("R3/R4 read address", {8'd0, bus_addr}, {8'd0, srca});
        chk("R2 read size", {31'd0, bus_size}, {31'd0, m_word});
        m_buf = m_word ? pat(srca) : {8'h00, pat(srca)[7:0]};
        m_ph  = 2;
      end else if (hs && m_ph == 2) begin
        chk("R3/R4 write address", {8'd0, bus_addr}, {8'd0, dsta});
        chk("R10 write data", {16'd0, bus_wdata}, {16'd0, m_buf});
        if (m_down) m_mem = m_mem - (m_word ? 24'd2 : 24'd1);
        else        m_mem = m_mem + (m_word ? 24'd2 : 24'd1);
        m_cnt = m_cnt - 16'd1;
        if (m_cnt == 16'd0) begin
          m_en = 0; m_done = 1; m_pv = 0;
        end
        m_ph = 0;
      end
    end
    if (we) begin
      case (wa)
        2'd0: m_mem = wd;
        2'd1: m_io  = wd[7:0];
        2'd2: m_cnt = wd[15:0];
        default: begin
          m_en = wd[0]; m_word = wd[1]; m_down = wd[2];
          if (wd[0]) m_done = 0;
        end
      endcase
    end
    if (hs) begin
      wcnt = 0;
      lat  = (lat + 1) % 3;
    end
  endtask

  task automatic step(input bit rq, input bit rx, input bit we,
                      input logic [1:0] wa, input logic [23:0] wd);
    @(negedge clk);
    compare();
    req_valid = rq; req_rx = rx; cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    if (bus_valid) begin
      bus_rdata = pat(bus_addr);
      if (wcnt >= lat) bus_ready = 1'b1;
      else begin bus_ready = 1'b0; wcnt++; end
    end else begin
      bus_ready = 1'b0;
    end
    hold_pend = bus_valid && !bus_ready;
    hold_addr = bus_addr;
    advance(rq, rx, we, wa, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 2'd0, 24'd0);
  endtask
  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    step(0, 0, 1, a, d);
  endtask
  task automatic req(input bit rx);
    step(1, rx, 0, 2'd0, 24'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_valid = 0; req_rx = 0; bus_ready = 0; bus_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1;
    idle(4);
    // R1 reset state
    chk("R1 reset valid", {31'd0, bus_valid}, 32'd0);
    chk("R1 reset enable", {31'd0, ch_enable}, 32'd0);
    chk("R1 reset done", {31'd0, ch_done}, 32'd0);
    chk("R1 reset count", {16'd0, ch_count}, 32'd0);
    chk("R1 reset pointer", {8'd0, ch_mem_addr}, 32'd0);

    // byte, upward, memory to I/O
    wr(2'd0, 24'h012340);
    wr(2'd1, 24'h00007C);
    wr(2'd2, 24'h000003);
    wr(2'd3, 24'h000001);
    idle(1);
    chk("R1 pointer load", {8'd0, ch_mem_addr}, 32'h012340);
    for (int i = 0; i < 3; i++) begin req(0); idle(10); end
    chk("R6 done after three", {31'd0, ch_done}, 32'd1);
    chk("R6 enable cleared", {31'd0, ch_enable}, 32'd0);
    chk("R5 byte up pointer", {8'd0, ch_mem_addr}, 32'h012343);

    // R7 requests ignored after completion
    for (int i = 0; i < 4; i++) begin req(i % 2); idle(3); end
    chk("R7 count unchanged", {16'd0, ch_count}, 32'd0);
    chk("R7 pointer unchanged", {8'd0, ch_mem_addr}, 32'h012343);
    chk("R7 still done", {31'd0, ch_done}, 32'd1);

    // word, downward, receiver source, burst of requests
    wr(2'd0, 24'h0200A0);
    wr(2'd1, 24'h000015);
    wr(2'd2, 24'h000005);
    wr(2'd3, 24'h000007);
    idle(1);
    chk("R1 done cleared by enable", {31'd0, ch_done}, 32'd0);
    req(1); req(1); req(1); req(1);
    idle(20);
    chk("R8 one held request", {16'd0, ch_count}, 32'd3);
    chk("R5 word down pointer", {8'd0, ch_mem_addr}, 32'h02009C);
    for (int i = 0; i < 3; i++) begin req(1); idle(10); end
    chk("R6 done word run", {31'd0, ch_done}, 32'd1);
    chk("R5 word down final", {8'd0, ch_mem_addr}, 32'h020096);

    // held request keeps its own direction
    wr(2'd0, 24'h000100);
    wr(2'd2, 24'h000002);
    wr(2'd3, 24'h000003);
    req(0); req(1);
    idle(20);
    chk("R8 held direction done", {31'd0, ch_done}, 32'd1);
    chk("R5 word up pointer", {8'd0, ch_mem_addr}, 32'h000104);
    idle(3);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule